// File: doc/BRIEF.md
# SGMII Auto-Negotiation MAC Responder

This block is the MAC-side control logic for configuring a serial gigabit media link. The PHY works out the line rate and duplex on its copper side. It then reports them to the MAC in 16-bit configuration words, which arrive here already recovered from the ordered-set stream. The MAC never picks a rate. It checks that the PHY's word is stable, latches it, and answers with an acknowledging word. It holds that answer for a link timer, then declares negotiation complete and opens the data path.

While it waits, the block returns a word with only the always-one bit set. Once it has accepted a link-up word, it returns the same word with the acknowledge bit added. If the PHY later sends a different word, negotiation starts again with the new information. A link-down word, or silence from the PHY during the acknowledge phase, sends the block back to waiting. Half-duplex gigabit and the reserved speed code are flagged as errors, and an errored link never carries data.

Top module: `sgmii_an_responder`

## Requirements
- R1: After reset, `link_up_o`, `an_complete_o` and `data_en_o` are 0, `tx_cfg_en_o` is 1, `tx_cfg_word_o` is 0x0001 and `lp_status_o` is 0x0000.
- R2: Fields of the partner word: bit 15 is link (1 = up) and bit 12 is duplex (1 = full). Bits 11:10 are speed: 10 = 1G, 01 = 100M, 00 = 10M, 11 = reserved. `speed_o` carries bits 11:10 and `full_duplex_o` carries bit 12 of the accepted word while `link_up_o` is 1. Both are 0 while the link is down. For example, 0xD801 decodes as 1G full duplex and 0xD401 as 100M full duplex.
- R3: A word is accepted only at the third received word in a row with the same value, ignoring bit 14. A different word in between restarts the count. Cycles without a word do not break the run. The count starts afresh when the block returns to waiting.
- R4: On the clock edge that accepts a word with bit 15 set, the block leaves waiting. From then on `link_up_o` is 1 and `tx_cfg_word_o` is 0x4001.
- R5: `an_complete_o` rises exactly LINK_TIMER cycles after the accepting edge. From then on `tx_cfg_en_o` is 0.
- R6: `data_en_o` is 1 only while `an_complete_o` is 1 and `an_error_o` is 0.
- R7: An accepted word whose bits other than 14 differ from the latched word restarts the handshake. This applies during the acknowledge phase and after completion. `an_complete_o` drops, the new fields appear, and completion follows LINK_TIMER cycles later.
- R8: An accepted word with bit 15 clear returns the block to waiting. `link_up_o` goes to 0 and `tx_cfg_word_o` goes back to 0x0001.
- R9: During the acknowledge phase, LOSS_CYCLES consecutive cycles without a received word return the block to waiting. After completion, missing words have no effect.
- R10: `an_error_o` is 1 while the link is up and the accepted word is half-duplex 1G or uses speed code 11.
- R11: `lp_status_o` holds the last accepted raw word, bit 14 included. It changes only on a clock edge that samples a received word.
- R12: An accepted word that differs from the latched word only in bit 14 has no effect. The state and `lp_status_o` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_cfg_valid_i | input | 1 | A configuration word from the PHY is present this cycle |
| rx_cfg_word_i | input | 16 | Received configuration word |
| tx_cfg_en_o | output | 1 | Send configuration words (1) or normal traffic (0) |
| tx_cfg_word_o | output | 16 | Configuration word to return to the PHY |
| link_up_o | output | 1 | A link-up word has been accepted and the handshake is active or done |
| an_complete_o | output | 1 | Negotiation complete |
| an_error_o | output | 1 | Negotiated mode is not allowed |
| data_en_o | output | 1 | Data frames may be sent and received |
| speed_o | output | 2 | Negotiated speed code |
| full_duplex_o | output | 1 | Negotiated full duplex |
| lp_status_o | output | 16 | Image of the last accepted partner word |

## Verification
A wrong state in the handshake shows up at the ports one cycle after the edge that caused it. `tx_cfg_word_o`, `tx_cfg_en_o` and the data gate are all decoded directly from the registered state, so an early or missing transition changes the returned word at once. Timer faults show only at the completion edge, which is checked on both sides of the boundary. Filter faults show as acceptance one word too early or too late.

// File: rtl/sgmii_an_pkg.sv
package sgmii_an_pkg;

  localparam int unsigned CFG_W      = 16;
  localparam int unsigned LINK_BIT   = 15;
  localparam int unsigned ACK_BIT    = 14;
  localparam int unsigned DUPLEX_BIT = 12;
  localparam int unsigned SPD_HI     = 11;
  localparam int unsigned SPD_LO     = 10;

  localparam logic [CFG_W-1:0] MAC_WAIT_WORD = 16'h0001;
  localparam logic [CFG_W-1:0] MAC_ACK_WORD  = 16'h4001;

  typedef enum logic [1:0] {
    SPD_10M  = 2'b00,
    SPD_100M = 2'b01,
    SPD_1G   = 2'b10,
    SPD_RSVD = 2'b11
  } speed_e;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_ACK  = 2'd1,
    ST_UP   = 2'd2
  } an_state_e;

  typedef struct packed {
    logic   link;
    logic   full_dup;
    speed_e speed;
  } cfg_info_t;

  function automatic cfg_info_t decode_cfg(input logic [CFG_W-1:0] w);
    cfg_info_t i;
    i.link     = w[LINK_BIT];
    i.full_dup = w[DUPLEX_BIT];
    i.speed    = speed_e'(w[SPD_HI:SPD_LO]);
    return i;
  endfunction

  function automatic logic [CFG_W-1:0] strip_ack(input logic [CFG_W-1:0] w);
    logic [CFG_W-1:0] r;
    r = w;
    r[ACK_BIT] = 1'b0;
    return r;
  endfunction

  function automatic logic bad_mode(input cfg_info_t i);
    return (i.speed == SPD_RSVD) || ((i.speed == SPD_1G) && !i.full_dup);
  endfunction

endpackage

// File: rtl/sgmii_an_rx_filter.sv
module sgmii_an_rx_filter
  import sgmii_an_pkg::*;
#(
  parameter int unsigned ACCEPT_CNT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             valid_i,
  input  logic [CFG_W-1:0] word_i,
  output logic             accept_o
);

  localparam int unsigned CNT_W = (ACCEPT_CNT > 2) ? $clog2(ACCEPT_CNT) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(ACCEPT_CNT - 1);

  logic [CFG_W-1:0] last_q;
  logic [CNT_W-1:0] cnt_q;
  logic             match;

  assign match = (strip_ack(word_i) == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      last_q <= '0;
      cnt_q  <= '0;
    end else if (valid_i) begin
      last_q <= strip_ack(word_i);
      if (!match)                cnt_q <= CNT_W'(1);
      else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
    end
  end

  // stable run reached: this word is the ACCEPT_CNT-th identical one or later
  assign accept_o = valid_i && match && (cnt_q == CNT_TOP);

endmodule

// File: rtl/sgmii_an_timer.sv
module sgmii_an_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);

  localparam int unsigned CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= done_o ? '0 : cnt_q + 1'b1;
  end

endmodule

// File: rtl/sgmii_an_fsm.sv
module sgmii_an_fsm
  import sgmii_an_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [CFG_W-1:0] word_i,
  input  logic             link_done_i,
  input  logic             loss_done_i,
  output an_state_e        state_o,
  output logic [CFG_W-1:0] partner_o,
  output logic             link_tmr_clr_o,
  output logic             link_tmr_en_o,
  output logic             filt_clr_o
);

  an_state_e        state_q, state_d;
  logic [CFG_W-1:0] partner_q, partner_d;
  logic             restart;
  logic             changed;
  cfg_info_t        rx_info;

  assign rx_info = decode_cfg(word_i);
  assign changed = (strip_ack(word_i) != strip_ack(partner_q));

  always_comb begin
    state_d   = state_q;
    partner_d = partner_q;
    restart   = 1'b0;
    unique case (state_q)
      ST_WAIT: begin
        if (accept_i) begin
          partner_d = word_i;
          if (rx_info.link) state_d = ST_ACK;
        end
      end
      ST_ACK, ST_UP: begin
        if (accept_i && changed) begin
          partner_d = word_i;
          restart   = 1'b1;
          state_d   = rx_info.link ? ST_ACK : ST_WAIT;
        end else if ((state_q == ST_ACK) && loss_done_i) begin
          state_d = ST_WAIT;
        end else if ((state_q == ST_ACK) && link_done_i) begin
          state_d = ST_UP;
        end
      end
      default: state_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_WAIT;
      partner_q <= '0;
    end else begin
      state_q   <= state_d;
      partner_q <= partner_d;
    end
  end

  assign state_o        = state_q;
  assign partner_o      = partner_q;
  assign link_tmr_en_o  = (state_q == ST_ACK);
  assign link_tmr_clr_o = (state_q != ST_ACK) || restart;
  assign filt_clr_o     = (state_d == ST_WAIT) && (state_q != ST_WAIT);

endmodule

// File: rtl/sgmii_an_responder.sv
module sgmii_an_responder
  import sgmii_an_pkg::*;
#(
  parameter int unsigned ACCEPT_CNT  = 3,
  parameter int unsigned LINK_TIMER  = 200000,
  parameter int unsigned LOSS_CYCLES = 256
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_cfg_valid_i,
  input  logic [15:0] rx_cfg_word_i,
  output logic        tx_cfg_en_o,
  output logic [15:0] tx_cfg_word_o,
  output logic        link_up_o,
  output logic        an_complete_o,
  output logic        an_error_o,
  output logic        data_en_o,
  output logic [1:0]  speed_o,
  output logic        full_duplex_o,
  output logic [15:0] lp_status_o
);

  logic             accept;
  logic             filt_clr;
  logic             link_done, loss_done;
  logic             link_clr, link_en;
  logic             loss_clr, loss_en;
  an_state_e        state;
  logic [CFG_W-1:0] partner;
  cfg_info_t        info;
  logic             linked;

  sgmii_an_rx_filter #(.ACCEPT_CNT(ACCEPT_CNT)) u_filter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (filt_clr),
    .valid_i  (rx_cfg_valid_i),
    .word_i   (rx_cfg_word_i),
    .accept_o (accept)
  );

  sgmii_an_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .accept_i       (accept),
    .word_i         (rx_cfg_word_i),
    .link_done_i    (link_done),
    .loss_done_i    (loss_done),
    .state_o        (state),
    .partner_o      (partner),
    .link_tmr_clr_o (link_clr),
    .link_tmr_en_o  (link_en),
    .filt_clr_o     (filt_clr)
  );

  sgmii_an_timer #(.LIMIT(LINK_TIMER)) u_link_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (link_clr),
    .en_i   (link_en),
    .done_o (link_done)
  );

  // silence watchdog, only meaningful while acknowledging
  assign loss_en  = (state == ST_ACK) && !rx_cfg_valid_i;
  assign loss_clr = (state != ST_ACK) || rx_cfg_valid_i;

  sgmii_an_timer #(.LIMIT(LOSS_CYCLES)) u_loss_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (loss_clr),
    .en_i   (loss_en),
    .done_o (loss_done)
  );

  assign info   = decode_cfg(partner);
  assign linked = (state != ST_WAIT);

  assign link_up_o     = linked;
  assign an_complete_o = (state == ST_UP);
  assign an_error_o    = linked && bad_mode(info);
  assign data_en_o     = (state == ST_UP) && !bad_mode(info);
  assign speed_o       = linked ? info.speed : SPD_10M;
  assign full_duplex_o = linked && info.full_dup;
  assign tx_cfg_en_o   = (state != ST_UP);
  assign tx_cfg_word_o = linked ? MAC_ACK_WORD : MAC_WAIT_WORD;
  assign lp_status_o   = partner;

endmodule

// File: rtl/sgmii_an_responder_chk.sv
module sgmii_an_responder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rx_cfg_valid_i,
  input logic        tx_cfg_en_o,
  input logic [15:0] tx_cfg_word_o,
  input logic        link_up_o,
  input logic        an_complete_o,
  input logic        an_error_o,
  input logic        data_en_o,
  input logic [1:0]  speed_o,
  input logic        full_duplex_o,
  input logic [15:0] lp_status_o
);

  AST_DATA_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_en_o |-> (an_complete_o && !an_error_o)); // R6

  AST_ACK_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_up_o |-> (tx_cfg_word_o == 16'h4001)); // R4

  AST_WAIT_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_up_o |-> (tx_cfg_en_o && tx_cfg_word_o == 16'h0001 && !an_complete_o)); // R8

  AST_COMPLETE_STOPS_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    an_complete_o |-> (link_up_o && !tx_cfg_en_o)); // R5

  AST_COMPLETE_FROM_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(an_complete_o) |-> $past(link_up_o)); // R5

  AST_HALF_GIG_ERROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_up_o && speed_o == 2'b10 && !full_duplex_o) |-> an_error_o); // R10

  AST_DOWN_FIELDS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_up_o |-> (speed_o == 2'b00 && !full_duplex_o && !an_error_o)); // R2

  AST_STATUS_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_cfg_valid_i |=> $stable(lp_status_o)); // R11

endmodule

bind sgmii_an_responder sgmii_an_responder_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .rx_cfg_valid_i (rx_cfg_valid_i),
  .tx_cfg_en_o    (tx_cfg_en_o),
  .tx_cfg_word_o  (tx_cfg_word_o),
  .link_up_o      (link_up_o),
  .an_complete_o  (an_complete_o),
  .an_error_o     (an_error_o),
  .data_en_o      (data_en_o),
  .speed_o        (speed_o),
  .full_duplex_o  (full_duplex_o),
  .lp_status_o    (lp_status_o)
);

// File: tb/sgmii_an_responder_bench.sv
`timescale 1ns/1ps
module sgmii_an_responder_bench;

  localparam int unsigned LT   = 16;
  localparam int unsigned LOSS = 8;
  localparam int unsigned NVEC = 8;

  // {word[15:0], link, full_dup, speed[1:0], err}
  localparam logic [20:0] VEC [NVEC] = '{
    {16'hD801, 1'b1, 1'b1, 2'b10, 1'b0},
    {16'hD401, 1'b1, 1'b1, 2'b01, 1'b0},
    {16'hD001, 1'b1, 1'b1, 2'b00, 1'b0},
    {16'h9801, 1'b1, 1'b1, 2'b10, 1'b0},
    {16'h8801, 1'b1, 1'b0, 2'b10, 1'b1},
    {16'h9C01, 1'b1, 1'b1, 2'b11, 1'b1},
    {16'h8401, 1'b1, 1'b0, 2'b01, 1'b0},
    {16'h1801, 1'b0, 1'b0, 2'b00, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [15:0] rx_word = '0;
  logic        tx_en;
  logic [15:0] tx_word;
  logic        link_up, complete, err, data_en, full_dup;
  logic [1:0]  speed;
  logic [15:0] lp_status;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sgmii_an_responder #(
    .ACCEPT_CNT (3),
    .LINK_TIMER (LT),
    .LOSS_CYCLES(LOSS)
  ) u_sgmii_an_responder (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .rx_cfg_valid_i (rx_valid),
    .rx_cfg_word_i  (rx_word),
    .tx_cfg_en_o    (tx_en),
    .tx_cfg_word_o  (tx_word),
    .link_up_o      (link_up),
    .an_complete_o  (complete),
    .an_error_o     (err),
    .data_en_o      (data_en),
    .speed_o        (speed),
    .full_duplex_o  (full_dup),
    .lp_status_o    (lp_status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  // drive n words at falling edges; outputs seen afterwards reflect words driven before the last step
  task automatic drive(input logic v, input logic [15:0] w, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_valid = v;
      rx_word  = w;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rx_valid = 1'b0; rx_word = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    // R1 reset state
    do_reset();
    check("R1 link_up", link_up, 0);
    check("R1 complete", complete, 0);
    check("R1 data_en", data_en, 0);
    check("R1 tx_en", tx_en, 1);
    check("R1 tx_word", tx_word, 16'h0001);
    check("R1 lp_status", lp_status, 0);

    // table walk: R2 R4 R5 R6 R10 R11
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] w;
      logic        e_link, e_fd, e_err;
      logic [1:0]  e_spd;
      {w, e_link, e_fd, e_spd, e_err} = VEC[i];
      do_reset();
      drive(1'b1, w, 3);
      drive(1'b1, w, 1);
      check("R4 link_up", link_up, e_link);
      check("R4 tx_word", tx_word, e_link ? 16'h4001 : 16'h0001);
      check("R2 speed", speed, e_spd);
      check("R2 duplex", full_dup, e_fd);
      check("R10 error", err, e_err);
      check("R11 lp_status", lp_status, w);
      check("R6 data_en in ack", data_en, 0);
      if (e_link) begin
        drive(1'b1, w, LT - 1);
        check("R5 complete before timer", complete, 0);
        drive(1'b1, w, 1);
        check("R5 complete at timer", complete, 1);
        check("R5 tx_en off", tx_en, 0);
        check("R6 data_en", data_en, !e_err);
      end
    end

    // R3 consistency filter
    do_reset();
    drive(1'b1, 16'hD801, 2);
    drive(1'b1, 16'hD401, 1);
    drive(1'b1, 16'hD401, 1);
    check("R3 no accept after break", link_up, 0);
    drive(1'b1, 16'hD401, 1);
    check("R3 no accept at two", link_up, 0);
    drive(1'b1, 16'hD401, 1);
    check("R3 accept at three", link_up, 1);
    check("R3 speed", speed, 2'b01);
    // complete with 100M
    drive(1'b1, 16'hD401, LT);
    check("R5 complete 100M", complete, 1);
    drive(1'b0, 16'h0000, 4);
    check("R9 idle after complete", complete, 1);

    // R12 bit 14 difference only
    drive(1'b1, 16'h9401, 3);
    drive(1'b0, 16'h0000, 1);
    check("R12 complete kept", complete, 1);
    check("R12 lp_status kept", lp_status, 16'hD401);

    // R7 restart after completion
    drive(1'b1, 16'hD801, 3);
    drive(1'b1, 16'hD801, 1);
    check("R7 complete dropped", complete, 0);
    check("R7 tx_en back", tx_en, 1);
    check("R7 new speed", speed, 2'b10);
    check("R11 lp_status new", lp_status, 16'hD801);
    drive(1'b1, 16'hD801, LT - 1);
    check("R7 timer restarted", complete, 0);
    drive(1'b1, 16'hD801, 1);
    check("R7 complete again", complete, 1);

    // R8 link-down word
    drive(1'b1, 16'h5801, 3);
    drive(1'b0, 16'h0000, 1);
    check("R8 link_up", link_up, 0);
    check("R8 tx_word", tx_word, 16'h0001);
    check("R8 complete", complete, 0);
    check("R8 lp_status", lp_status, 16'h5801);

    // R9 loss during ack
    do_reset();
    drive(1'b1, 16'hD801, 3);
    drive(1'b0, 16'h0000, 1);
    check("R9 acked", link_up, 1);
    drive(1'b0, 16'h0000, LOSS - 1);
    check("R9 before loss", link_up, 1);
    drive(1'b0, 16'h0000, 1);
    check("R9 loss to wait", link_up, 0);
    check("R9 tx_word", tx_word, 16'h0001);
    // R3 filter restarted on return to waiting; gaps do not break a run
    drive(1'b1, 16'hD801, 2);
    drive(1'b0, 16'h0000, 1);
    check("R3 count restarted", link_up, 0);
    drive(1'b1, 16'hD801, 1);
    drive(1'b0, 16'h0000, 1);
    check("R3 gap tolerated", link_up, 1);

    finish_run();
  end

endmodule